// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path with Deselect Timing

This block sits between the storage array of a synchronous SRAM and its data pins. Each clock edge it captures one command: start a read, continue the current access, or deselect. It then delivers the array's read word to the output bus and decides when the output drivers are active. Two static mode inputs shape the timing. The first chooses whether read data goes straight from the array to the pins (flow-through) or passes through a rising-edge output register first (pipelined). The second chooses how quickly the drivers turn off after a deselect. With single-cycle deselect, turn-off comes one stage ahead of the read data. With dual-cycle deselect, turn-off comes at the same pipeline depth as the read data.

An output-enable input gates the internal output-active flag without waiting for a clock edge. The bus is driven only when the flag and the enable are both true. A high-impedance bus is modelled as a separate drive-enable output, with the data lines held at zero while not driven. A synchronous reset returns every stage to the deselected state. The mode inputs are meant to be changed only while reset is held.

Top module: `sram_rd_outpath`

## Requirements
- R1: While `rst` is high at a rising edge, the capture stage and the output stage both return to deselected. In the cycle after such an edge, `dq_oe` is 0 and `dq_out` is 0.
- R2: With `pipe_sel`=0 (flow-through), a read captured at edge k makes `dq_oe` high in the cycle after edge k. In that same cycle `dq_out` follows `arr_rdata` combinationally, which gives a 2-cycle first access counted from the cycle the command is presented.
- R3: With `pipe_sel`=1 (pipelined), `dq_out` shows the `arr_rdata` value that was present in the cycle before the last rising edge. This gives a 3-cycle first access counted from the cycle the command is presented.
- R4: Command encoding on `cmd`: 2'b01 is read, 2'b10 is deselect, and 2'b00 or 2'b11 is continue. A continue keeps the previous select state, so each further burst beat appears one cycle after the one before.
- R5: With `pipe_sel`=1 and `dual_desel`=0 (single-cycle deselect, the default pair), a deselect captured at edge k drives `dq_oe` low in the cycle after edge k.
- R6: With `pipe_sel`=1 and `dual_desel`=1, a deselect captured at edge k leaves the output-active flag unchanged for the cycle after edge k and clears it after edge k+1. With `pipe_sel`=0, a deselect turns the output off in the cycle after edge k in both deselect modes.
- R7: `out_en`=0 forces `dq_oe` to 0 within the same cycle, with no clock edge needed. Raising `out_en` again restores the drive in the same cycle.
- R8: A read captured the edge right after a deselect delivers valid data and drive at its normal latency for the selected output mode.
- R9: Whenever `dq_oe` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pipe_sel | input | 1 | 1 = pipelined output, 0 = flow-through |
| dual_desel | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect |
| cmd | input | 2 | Command captured each edge (read / deselect / continue) |
| arr_rdata | input | DATA_W | Read word from the array for the captured access |
| out_en | input | 1 | Asynchronous output enable, active high |
| dq_out | output | DATA_W | Output data bus, zero when not driven |
| dq_oe | output | 1 | Output driver enable |

## Verification
The same command pattern runs in all four mode combinations: a four-beat burst, a deselect, a read straight after that deselect, a read followed at once by a deselect, and an enable toggle mid-burst. Comparing the runs shows the one-cycle latency difference between flow-through and pipelined output. It also shows the one-cycle difference in turn-off between single and dual deselect, which appears only in pipelined mode. The read right after a deselect shows that the turn-off path does not disturb the next access. Changing the array word every cycle confirms that each beat carries its own word and not a stale register value.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_DESEL = 2'b10,
        CMD_RSVD  = 2'b11
    } rdp_cmd_e;

    typedef struct packed {
        logic act;
    } sel_stage_t;

    function automatic logic next_select(input rdp_cmd_e c, input logic cur);
        case (c)
            CMD_READ:  return 1'b1;
            CMD_DESEL: return 1'b0;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/rdp_capture.sv
module rdp_capture
    import rdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd,
    output logic       s1_act
);

    sel_stage_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        cap_d.act = next_select(rdp_cmd_e'(cmd), cap_q.act);
        if (rst) begin
            cap_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign s1_act = cap_q.act;

    AST_CAP_RESET: assert property (@(posedge clk) rst |=> !s1_act) // R1
        else $error("capture stage not cleared by reset");

endmodule

// File: rtl/rdp_outreg.sv
module rdp_outreg
    import rdp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_act,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              s2_act,
    output logic [DATA_W-1:0] s2_data
);

    localparam int LANES = DATA_W / LANE_W;

    sel_stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.act = s1_act;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign s2_act = st_q.act;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (rst) begin
                lane_d = '0;
            end else if (s1_act) begin
                lane_d = arr_rdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            lane_q <= lane_d;
        end

        assign s2_data[g*LANE_W +: LANE_W] = lane_q;
    end

    AST_OUT_RESET: assert property (@(posedge clk) rst |=> (!s2_act && s2_data == '0)) // R1
        else $error("output stage not cleared by reset");

endmodule

// File: rtl/rdp_drive.sv
module rdp_drive #(
    parameter int DATA_W = 32
) (
    input  logic              pipe_sel,
    input  logic              dual_desel,
    input  logic              s1_act,
    input  logic              s2_act,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] s2_data,
    input  logic              out_en,
    output logic              act_int,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic [DATA_W-1:0] sel_data;

    always_comb begin
        if (pipe_sel) begin
            act_int  = s2_act & (dual_desel | s1_act);
            sel_data = s2_data;
        end else begin
            act_int  = s1_act;
            sel_data = arr_rdata;
        end
        dq_oe  = act_int & out_en;
        dq_out = dq_oe ? sel_data : '0;
    end

endmodule

// File: rtl/sram_rd_outpath.sv
module sram_rd_outpath
    import rdp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_sel,
    input  logic              dual_desel,
    input  logic [1:0]        cmd,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              out_en,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              s1_act;
    logic              s2_act;
    logic [DATA_W-1:0] s2_data;
    logic              act_int;

    rdp_capture i_capture (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .s1_act (s1_act)
    );

    rdp_outreg #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_outreg (
        .clk       (clk),
        .rst       (rst),
        .s1_act    (s1_act),
        .arr_rdata (arr_rdata),
        .s2_act    (s2_act),
        .s2_data   (s2_data)
    );

    rdp_drive #(.DATA_W(DATA_W)) i_drive (
        .pipe_sel   (pipe_sel),
        .dual_desel (dual_desel),
        .s1_act     (s1_act),
        .s2_act     (s2_act),
        .arr_rdata  (arr_rdata),
        .s2_data    (s2_data),
        .out_en     (out_en),
        .act_int    (act_int),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dq_oe) // R1
        else $error("drive active after reset");

    AST_FT_READ_ON: assert property (@(posedge clk) disable iff (rst)
        (!pipe_sel && cmd == CMD_READ) |=> act_int) // R2
        else $error("flow-through read not active next cycle");

    AST_PIPE_DATA: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && dq_oe) |-> dq_out == $past(arr_rdata)) // R3
        else $error("pipelined data not one edge behind array");

    AST_SCD_EARLY: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && !dual_desel && cmd == CMD_DESEL) |=> !act_int) // R5
        else $error("single-cycle deselect late");

    AST_DCD_LATE: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && dual_desel && cmd == CMD_DESEL) |-> ##2 !act_int) // R6
        else $error("dual-cycle deselect not off after second edge");

    AST_FT_DESEL_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pipe_sel && cmd == CMD_DESEL) |=> !act_int) // R6
        else $error("flow-through deselect late");

    AST_REREAD_ON: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && dual_desel && cmd == CMD_READ) |-> ##2 act_int) // R8
        else $error("pipelined read not active at its latency");

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> dq_out == '0) // R9
        else $error("bus not zero while undriven");

endmodule

// File: tb/test_sram_rd_outpath.sv
module test_sram_rd_outpath;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_sel = 1'b1;
    logic          dual_desel = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [DW-1:0] arr_rdata = '0;
    logic          out_en = 1'b1;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #4 clk = ~clk;

    sram_rd_outpath #(.DATA_W(DW), .LANE_W(8)) i_sram_rd_outpath (
        .clk        (clk),
        .rst        (rst),
        .pipe_sel   (pipe_sel),
        .dual_desel (dual_desel),
        .cmd        (cmd),
        .arr_rdata  (arr_rdata),
        .out_en     (out_en),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    typedef struct {
        logic          drive;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 0;

    // bench model: a1 = select state of the current window, a2 = previous window
    logic          m_a1 = 0, m_a2 = 0;
    logic [DW-1:0] m_arrp = '0;

    localparam logic [1:0] C_HOLD = 2'b00, C_READ = 2'b01, C_DESEL = 2'b10, C_ALT = 2'b11;

    task automatic step(input logic [1:0] c, input logic [DW-1:0] d, input logic oe, input string tag);
        exp_t e;
        @(negedge clk);
        if (pipe_sel) begin
            e.drive = m_a2 && (dual_desel || m_a1) && oe;
            e.data  = m_arrp;
        end else begin
            e.drive = m_a1 && oe;
            e.data  = d;
        end
        if (!e.drive) e.data = '0;
        e.tag = tag;
        exp_q.push_back(e);
        cmd       = c;
        arr_rdata = d;
        out_en    = oe;
        m_a2   = m_a1;
        m_arrp = d;
        if (c == C_READ) m_a1 = 1'b1;
        else if (c == C_DESEL) m_a1 = 1'b0;
    endtask

    task automatic do_reset(input logic p, input logic dd);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; cmd = C_HOLD; pipe_sel = p; dual_desel = dd; out_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        e.drive = 1'b0; e.data = '0; e.tag = "R1 reset";
        exp_q.push_back(e);
        rst = 1'b0;
        m_a1 = 0; m_a2 = 0; m_arrp = '0;
    endtask

    // monitor: compare 1 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (dq_oe !== e.drive || dq_out !== e.data) begin
                    n_bad++;
                    $display("FAIL %s pipe=%0b dual=%0b: oe=%0b data=%h expected oe=%0b data=%h",
                             e.tag, pipe_sel, dual_desel, dq_oe, dq_out, e.drive, e.data);
                end
            end
        end
    end

    task automatic run_mode(input logic p, input logic dd);
        string lat;
        lat = p ? "R3" : "R2";
        do_reset(p, dd);
        step(C_READ,  32'h1100_0001, 1, "R1 idle after reset");
        step(C_HOLD,  32'h2200_0002, 1, {lat, " first beat"});
        step(C_HOLD,  32'h3300_0003, 1, "R4 burst beat");
        step(C_ALT,   32'h4400_0004, 1, "R4 burst beat alt continue");
        step(C_DESEL, 32'h5500_0005, 1, "R4 burst beat");
        step(C_READ,  32'h6600_0006, 1, dd ? "R6 deselect" : "R5 deselect");
        step(C_HOLD,  32'h7700_0007, 1, "R6 deselect depth");
        step(C_READ,  32'h8800_0008, 1, "R8 read after deselect");
        step(C_DESEL, 32'h9900_0009, 1, "R8 read after deselect");
        step(C_HOLD,  32'hAA00_000A, 1, "R5 R6 read then deselect");
        step(C_HOLD,  32'hBB00_000B, 1, "R9 idle zero");
        step(C_READ,  32'hCC00_000C, 1, "R9 idle zero");
        step(C_HOLD,  32'hDD00_000D, 1, lat);
        step(C_HOLD,  32'hEE00_000E, 0, "R7 enable low");
        step(C_HOLD,  32'hFF00_000F, 1, "R7 enable restored");
        step(C_DESEL, 32'h1200_0010, 0, "R7 enable low");
        step(C_HOLD,  32'h1300_0011, 1, "R6 R5 off");
        step(C_HOLD,  32'h1400_0012, 1, "R9 idle zero");
    endtask

    initial begin
        run_mode(1'b1, 1'b0);
        run_mode(1'b1, 1'b1);
        run_mode(1'b0, 1'b0);
        run_mode(1'b0, 1'b1);
        // R7: enable dropped mid-cycle, observed with no edge in between
        do_reset(1'b0, 1'b0);
        step(C_READ, 32'h0BAD_0001, 1, "R7 setup");
        step(C_HOLD, 32'h0BAD_0002, 1, "R2 active");
        @(negedge clk);
        #1 out_en = 1'b0;
        #1;
        n_vec++;
        if (dq_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 async disable: oe=%0b expected oe=0", dq_oe);
        end
        #1 out_en = 1'b1;
        #0.5;
        n_vec++;
        if (dq_oe !== 1'b1) begin
            n_bad++;
            $display("FAIL R7 async enable: oe=%0b expected oe=1", dq_oe);
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule